// File: doc/BRIEF.md
# Prescaled Dual Tick Timer Unit

This block holds three 16-bit down-counters that software programs one byte at a time. The third counter, the prescaler, counts a master clock enable. Its terminal pulse is the advance enable for the other two counters. The first of those two gives a periodic tick interrupt. The second runs freely over a long count, and its wrap interrupt lets software extend a timecount.

Software starts a counter with a control write that selects it and arms rate-generator mode. It then writes the reload value as a low byte followed by a high byte. A latch command takes a snapshot of a counter, and the snapshot is read back low byte first. A stop command parks a counter. Each of the two interrupt lines is a sticky flag. A write to the clear register removes a flag, one bit for each flag.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset both interrupt flags are low, every counter is parked with a count of zero, and reading counter 0's data address returns 0x00.
- R2: The prescaler (counter 2) advances on each cycle that `master_en` is high. Counters 0 and 1 advance only in cycles where the prescaler emits its pulse. With a prescaler reload of P and a counter 0 reload of N, ticks recur every P*N enabled master cycles.
- R3: A running counter steps down by one on each advance. On an advance from 2 it emits its pulse and goes to 1, and on the next advance it takes its reload value again, so the period equals the reload value for any reload of at least 2.
- R4: Address 3 is the control register. A control byte has the counter select in bits 7:6 and the command in bits 5:4, where 10 arms rate-generator mode. After arming, a write to the counter's data address (0, 1 or 2) supplies the low byte and the next write supplies the high byte. The count and reload change only when the high byte is written, and the counter is halted between the arm and that write.
- R5: Command 00 is latch. It captures the selected counter's count, and the next two reads of that counter's data address return the captured low byte and then the captured high byte, even if the counter has moved since the capture.
- R6: Address 4 is the clear register. Writing bit 0 as one clears the tick flag, and writing bit 1 as one clears the wrap flag. Zero bits and bits 7:2 have no effect. A flag stays set until it is cleared.
- R7: When a counter pulse and a clear of the same flag fall in one cycle, the flag ends up set.
- R8: Command 01 stops the selected counter. A stopped counter keeps its count, raises no flag, and ignores writes to its data address until it is armed again.
- R9: A pulse of counter 1 sets the wrap flag. A reload of 0xFFFF makes counter 1 step down from the top of the 16-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master clock enable that drives the prescaler |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Write address: 0..2 counter data, 3 control, 4 clear |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe; moves the selected counter's byte pointer |
| rd_addr | input | 3 | Read address, counter 0..2 |
| rd_data | output | 8 | Byte selected by rd_addr and the byte pointer |
| irq_tick | output | 1 | Sticky flag set by counter 0 |
| irq_wrap | output | 1 | Sticky flag set by counter 1 |

## Verification
The tick period is measured in four configurations: a steady master enable with prescale 8 and reload 5, the same setup with the master enable high only every other cycle, the minimum reload of 2, and a different prescale of 4. Together these separate a prescaler fault from a counter fault and expose an off-by-one in the reload step. With the master enable held low, single enable pulses move the counters by exact amounts. This makes the latch snapshot, the hold while only the low byte is written, and the set-over-clear collision checkable byte by byte. Clear writes with only the other flag's bit set, or only the unused bits set, show that those bits are ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      CNT_IDLE  = 2'd0,
      CNT_ARMED = 2'd1,
      CNT_RUN   = 2'd2
   } cnt_state_e;

   localparam logic [1:0] CMD_LATCH = 2'b00;
   localparam logic [1:0] CMD_STOP  = 2'b01;
   localparam logic [1:0] CMD_RATE  = 2'b10;

   localparam int NUM_CNT   = 3;
   localparam int NUM_FLAG  = 2;
   localparam int PRE_IDX   = 2;
   localparam int ADDR_CTRL = 3;
   localparam int ADDR_CLR  = 4;
endpackage

// File: rtl/tmr_sticky_flag.sv
module tmr_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       adv,
   input  logic       ctl_wr,
   input  logic [1:0] ctl_cmd,
   input  logic       data_wr,
   input  logic [7:0] data_byte,
   input  logic       rd_strobe,
   output logic       pulse,
   output logic [7:0] rd_byte
);
   localparam int NB = CNT_W / 8;
   localparam int PW = (NB > 1) ? $clog2(NB) : 1;

   cnt_state_e        state;
   logic [CNT_W-1:0]  count;
   logic [CNT_W-1:0]  reload;
   logic [CNT_W-1:0]  snap;
   logic [CNT_W-1:0]  view;
   logic [CNT_W-9:0]  stage;
   logic [PW-1:0]     wr_ptr;
   logic [PW-1:0]     rd_ptr;
   logic              held;
   logic              ctl_halt;
   logic              last_byte;
   logic              load_now;
   logic              run_step;

   assign ctl_halt  = ctl_wr && (ctl_cmd == CMD_STOP || ctl_cmd == CMD_RATE);
   assign last_byte = (wr_ptr == PW'(NB - 1));
   assign load_now  = data_wr && (state != CNT_IDLE) && last_byte && !ctl_halt;
   assign run_step  = (state == CNT_RUN) && adv && !ctl_halt && !load_now;
   assign pulse     = run_step && (count == CNT_W'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= CNT_IDLE;
         count  <= '0;
         reload <= '0;
         stage  <= '0;
         wr_ptr <= '0;
      end else if (ctl_halt) begin
         if (ctl_cmd == CMD_STOP) begin
            state <= CNT_IDLE;
         end else begin
            state  <= CNT_ARMED;
            wr_ptr <= '0;
         end
      end else if (data_wr && state != CNT_IDLE) begin
         if (last_byte) begin
            reload <= {data_byte, stage};
            count  <= {data_byte, stage};
            state  <= CNT_RUN;
            wr_ptr <= '0;
         end else begin
            stage[8*int'(wr_ptr) +: 8] <= data_byte;
            wr_ptr <= wr_ptr + PW'(1);
         end
      end else if (run_step) begin
         count <= (count == CNT_W'(1)) ? reload : count - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held   <= 1'b0;
         snap   <= '0;
         rd_ptr <= '0;
      end else if (ctl_wr && ctl_cmd == CMD_LATCH) begin
         held   <= 1'b1;
         snap   <= count;
         rd_ptr <= '0;
      end else if (rd_strobe) begin
         if (rd_ptr == PW'(NB - 1)) begin
            rd_ptr <= '0;
            held   <= 1'b0;
         end else begin
            rd_ptr <= rd_ptr + PW'(1);
         end
      end
   end

   assign view    = held ? snap : count;
   assign rd_byte = view[8*int'(rd_ptr) +: 8];
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              irq_tick,
   output logic              irq_wrap
);
   if (CNT_W < 16 || (CNT_W % 8) != 0) begin : g_bad_width
      $error("CNT_W must be a multiple of 8 and at least 16");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must reach the clear register");
   end

   logic [NUM_CNT-1:0]  cnt_pulse;
   logic [NUM_FLAG-1:0] flag_q;
   logic [NUM_FLAG-1:0] clr_hit;
   logic [7:0]          rd_bytes [NUM_CNT];
   logic                ctl_hit;
   logic                clr_sel;

   assign ctl_hit = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
   assign clr_sel = wr_en && (wr_addr == ADDR_W'(ADDR_CLR));

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      logic adv_i;
      if (i == PRE_IDX) begin : g_pre
         assign adv_i = master_en;
      end else begin : g_sub
         assign adv_i = cnt_pulse[PRE_IDX];
      end
      tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .adv       (adv_i),
         .ctl_wr    (ctl_hit && (wr_data[7:6] == 2'(i))),
         .ctl_cmd   (wr_data[5:4]),
         .data_wr   (wr_en && (wr_addr == ADDR_W'(i))),
         .data_byte (wr_data),
         .rd_strobe (rd_en && (rd_addr == ADDR_W'(i))),
         .pulse     (cnt_pulse[i]),
         .rd_byte   (rd_bytes[i])
      );
   end

   for (genvar j = 0; j < NUM_FLAG; j++) begin : g_flag
      assign clr_hit[j] = clr_sel && wr_data[j];
      tmr_sticky_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (cnt_pulse[j]),
         .clr   (clr_hit[j]),
         .q     (flag_q[j])
      );
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_CNT; k++) begin
         if (rd_addr == ADDR_W'(k)) rd_data = rd_bytes[k];
      end
   end

   assign irq_tick = flag_q[0];
   assign irq_wrap = flag_q[1];
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic [2:0]        pulse,
   input logic              irq_tick,
   input logic              irq_wrap
);
   logic clr_t;
   logic clr_w;
   assign clr_t = wr_en && (wr_addr == ADDR_W'(4)) && wr_data[0];
   assign clr_w = wr_en && (wr_addr == ADDR_W'(4)) && wr_data[1];

   // R2
   tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[0] |-> pulse[2]);
   // R2
   wrap_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[1] |-> pulse[2]);
   // R7
   tick_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[0] |=> irq_tick);
   // R9
   wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[1] |=> irq_wrap);
   // R6
   tick_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_t && !pulse[0]) |=> !irq_tick);
   // R6
   wrap_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && !pulse[1]) |=> !irq_wrap);
   // R6
   tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_tick && !clr_t) |=> irq_tick);
   // R8
   tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_tick && !pulse[0]) |=> !irq_tick);
endmodule

bind tick_timer_unit tick_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .pulse    (cnt_pulse),
   .irq_tick (irq_tick),
   .irq_wrap (irq_wrap)
);

// File: tb/tick_timer_unit_tb.sv
module tick_timer_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       gate = 1'b0;
   logic       alt = 1'b0;
   logic       phase = 1'b0;
   logic       master_en;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [2:0] rd_addr = '0;
   logic       scored = 1'b0;
   logic [7:0] rd_data;
   logic       irq_tick;
   logic       irq_wrap;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   typedef struct {
      logic [7:0] val;
      string      tag;
   } exp_t;
   exp_t exp_q[$];

   always #2 clk = ~clk;
   assign master_en = gate & (alt ? phase : 1'b1);

   always @(posedge clk) begin
      cyc   <= cyc + 1;
      phase <= ~phase;
   end

   tick_timer_unit u_dut (
      .clk(clk), .rst_n(rst_n), .master_en(master_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_tick(irq_tick), .irq_wrap(irq_wrap)
   );

   // monitor: pops expected bytes as scored reads appear
   always @(negedge clk) begin
      if (rd_en && scored) begin
         exp_t e;
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL read with empty scoreboard act=%02h exp=none", rd_data);
         end else begin
            e = exp_q.pop_front();
            if (rd_data !== e.val) begin
               errors++;
               $display("FAIL %s read act=%02h exp=%02h", e.tag, rd_data, e.val);
            end
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog act=%0d exp<=100000 cycles", cyc);
         $display("CHECKS %0d ERRORS %0d", checks + 1, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd_exp(input logic [2:0] a, input logic [7:0] v, input string tag);
      exp_t e;
      e.val = v; e.tag = tag;
      exp_q.push_back(e);
      rd_en = 1'b1; rd_addr = a; scored = 1'b1;
      @(posedge clk); #1;
      rd_en = 1'b0; scored = 1'b0;
   endtask

   task automatic rd_cap(input logic [2:0] a, output logic [7:0] v);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      v = rd_data;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic load(input logic [1:0] idx, input logic [15:0] val);
      wr(3'd3, {idx, 2'b10, 4'h0});
      wr({1'b0, idx}, val[7:0]);
      wr({1'b0, idx}, val[15:8]);
   endtask

   task automatic latch(input logic [1:0] idx);
      wr(3'd3, {idx, 2'b00, 4'h0});
   endtask

   task automatic one_shot();
      gate = 1'b1;
      @(posedge clk); #1;
      gate = 1'b0;
   endtask

   task automatic wait_flag(input bit wrap, output int t);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!(wrap ? irq_wrap : irq_tick) && n < 5000);
      t = cyc;
      if (n >= 5000) check(1'b0, "flag timeout", n, 0);
      @(posedge clk); #1;
      wr(3'd4, wrap ? 8'h02 : 8'h01);
   endtask

   task automatic measure(input bit wrap, input int exp, input string tag);
      int t0; int t1; int t2;
      wait_flag(wrap, t0);
      wait_flag(wrap, t1);
      wait_flag(wrap, t2);
      check((t2 - t1) == exp, tag, t2 - t1, exp);
   endtask

   initial begin
      logic [7:0] a0, a1, b0, b1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(irq_tick == 1'b0, "R1 tick flag", irq_tick, 0);
      check(irq_wrap == 1'b0, "R1 wrap flag", irq_wrap, 0);
      @(posedge clk); #1;
      rd_exp(3'd0, 8'h00, "R1");

      // R4 load and R5 latch, master held off
      load(2'd1, 16'h1234);
      latch(2'd1);
      rd_exp(3'd1, 8'h34, "R5");
      rd_exp(3'd1, 8'h12, "R5");
      wr(3'd3, {2'd1, 2'b10, 4'h0});
      wr(3'd1, 8'h78);
      latch(2'd1);
      rd_exp(3'd1, 8'h34, "R4");
      rd_exp(3'd1, 8'h12, "R4");
      wr(3'd1, 8'h56);
      latch(2'd1);
      rd_exp(3'd1, 8'h78, "R4");
      rd_exp(3'd1, 8'h56, "R4");

      // R5 snapshot survives a counter step; R2 single prescaled step
      load(2'd2, 16'd2);
      latch(2'd1);
      one_shot();
      rd_exp(3'd1, 8'h78, "R5");
      rd_exp(3'd1, 8'h56, "R5");
      latch(2'd1);
      rd_exp(3'd1, 8'h77, "R2");
      rd_exp(3'd1, 8'h56, "R2");

      // R7 set beats clear in the same cycle
      load(2'd2, 16'd2);
      load(2'd0, 16'd2);
      gate = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h01;
      @(posedge clk); #1;
      gate = 1'b0; wr_en = 1'b0;
      check(irq_tick == 1'b1, "R7 set wins", irq_tick, 1);

      // R6 clear register bits
      wr(3'd4, 8'h02);
      check(irq_tick == 1'b1, "R6 other bit", irq_tick, 1);
      wr(3'd4, 8'hFC);
      check(irq_tick == 1'b1, "R6 unused bits", irq_tick, 1);
      wr(3'd4, 8'h01);
      check(irq_tick == 1'b0, "R6 clear", irq_tick, 0);
      check(irq_wrap == 1'b0, "R6 wrap untouched", irq_wrap, 0);

      // R2 / R3 periods
      load(2'd2, 16'd8);
      load(2'd0, 16'd5);
      gate = 1'b1;
      measure(1'b0, 40, "R2 steady enable");
      alt = 1'b1;
      measure(1'b0, 80, "R2 half-rate enable");
      alt = 1'b0;
      load(2'd0, 16'd2);
      measure(1'b0, 16, "R3 reload two");
      load(2'd2, 16'd4);
      load(2'd0, 16'd3);
      measure(1'b0, 12, "R3 prescale four");

      // R8 stop
      wr(3'd3, {2'd0, 2'b01, 4'h0});
      wr(3'd4, 8'h01);
      wr(3'd0, 8'h02);
      wr(3'd0, 8'h00);
      repeat (100) @(posedge clk);
      #1;
      check(irq_tick == 1'b0, "R8 no tick", irq_tick, 0);
      latch(2'd0);
      rd_cap(3'd0, a0);
      rd_cap(3'd0, a1);
      repeat (50) @(posedge clk);
      #1;
      latch(2'd0);
      rd_cap(3'd0, b0);
      rd_cap(3'd0, b1);
      check({a1, a0} == {b1, b0}, "R8 count held", {b1, b0}, {a1, a0});

      // R9 wrap flag and full range
      load(2'd1, 16'd3);
      measure(1'b1, 12, "R9 wrap period");
      gate = 1'b0;
      load(2'd2, 16'd2);
      load(2'd1, 16'hFFFF);
      one_shot();
      latch(2'd1);
      rd_exp(3'd1, 8'hFE, "R9");
      rd_exp(3'd1, 8'hFF, "R9");

      repeat (2) @(posedge clk);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule